// File: doc/BRIEF.md
# Dual-Mode Branch Linkage Unit

This block is the branch and subroutine-linkage datapath of a 32-bit register machine that addresses memory in either a narrow 24-bit mode or a wide 31-bit mode. It holds the current instruction address and a one-bit addressing-mode flag. Each cycle in which a decoded branch operation is presented, it computes the next instruction address, the next mode, and an optional link word to be written back into the register file.

The operations are five families:
- link calls, which pack the instruction length code, condition code and program mask into the top byte of the return word;
- store calls, which save a clean 31-bit return address;
- a save-and-switch call, which records the caller's mode in bit 31 of the link word and takes the callee's mode from bit 31 of the target word;
- a switch-return, which branches to a word and adopts that word's mode bit;
- a masked conditional branch on register.

Together the save-and-switch call and the switch-return allow any caller mode to call any callee mode and return to the caller's mode.

The state register, the mode flag and the link write-back all update on the same clock edge. They are computed from the values held before that edge, so a link register that is also the branch target register behaves correctly.

Top module: `brl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_addr` becomes 0, `pc_amode` becomes 0 (24-bit mode) and `lk_we` becomes 0.
- R2: The operation codes on `in_op` are as follows. Register forms are 0 (link), 2 (store), 4 (save-and-switch), 5 (switch-return) and 6 (conditional). Indexed forms are 1 (link) and 3 (store). The return address is `pc_addr` plus 2 for register forms and plus 4 for indexed forms. It wraps to 24 bits in mode 0 and to 31 bits in mode 1.
- R3: Link calls (codes 0 and 1) write a link word to `in_f1` with these fields:
  - bits 31:30 hold the length code (01 for register form, 10 for indexed form);
  - bits 29:28 hold `in_cc`;
  - bits 27:24 hold `in_pmask`;
  - bits 23:0 hold the return address.
  The branch target is `in_r2_val` for code 0 and `in_ea` for code 1. The mode is unchanged.
- R4: Store calls (codes 2 and 3) write bit 31 = 0 and bits 30:0 = the return address. Their targets are chosen as in R3, and the mode is unchanged.
- R5: A branch target word is reduced to the address width of the mode in force after the branch. Mode 0 keeps bits 23:0. Mode 1 keeps bits 30:0. Bit 31 is never part of the address.
- R6: Save-and-switch (code 4) writes bit 31 = the current mode and bits 30:0 = the return address. It branches to `in_r2_val`, with the new mode taken from `in_r2_val[31]`.
- R7: Switch-return (code 5) branches to `in_r2_val` with the new mode taken from `in_r2_val[31]`. When `in_f1` is nonzero, it writes `in_r1_val` with bit 31 replaced by the current mode. When `in_f1` is 0, it writes nothing.
- R8: The conditional branch (code 6) tests one bit of `in_f1`: bit 3 for cc 0, bit 2 for cc 1, bit 1 for cc 2, and bit 0 for cc 3. It branches to `in_r2_val` in the current mode when that bit is set, falls through otherwise, and never writes a link.
- R9: A register-form operation with `in_f2` = 0 does not branch. The address becomes the return address and the mode is unchanged, but its link write still occurs.
- R10: The link outputs appear on the same edge as the address update and are formed from the pre-update address and mode, including when `in_f1` equals `in_f2`.
- R11: With `in_valid` low, or with code 7, the address and mode hold and `lk_we` is 0 after the edge.
- R12: A save-and-switch call followed by a switch-return through the saved word returns to the caller's address and mode for all four pairs: 24 to 24, 24 to 31, 31 to 24 and 31 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch operation is presented this cycle |
| in_op | input | 3 | Operation code (see R2) |
| in_f1 | input | 4 | First register field: link destination, or the condition mask |
| in_f2 | input | 4 | Second register field; 0 means no branch for register forms |
| in_r1_val | input | 32 | Contents of the register named by `in_f1` |
| in_r2_val | input | 32 | Contents of the register named by `in_f2` |
| in_ea | input | 32 | Effective address for indexed forms |
| in_cc | input | 2 | Current condition code |
| in_pmask | input | 4 | Current program mask |
| pc_addr | output | 31 | Current instruction address |
| pc_amode | output | 1 | Current addressing mode (0 = 24-bit, 1 = 31-bit) |
| lk_we | output | 1 | Link write-back valid |
| lk_idx | output | 4 | Link destination register |
| lk_val | output | 32 | Link word |

## Verification
The hardest situation to reach is a return into the opposite mode with an address that only the saved link word can supply. The return needs a call that captured the caller's mode, and that call in turn needs the caller to have been placed in a known mode first.

The bench therefore builds each of the four mode pairs in three steps:
1. a switch-return with no save places the caller in a chosen mode;
2. a save-and-switch call enters the callee;
3. the link word predicted by the bench's reference model is fed back as the return target.

Address wrap at both widths is reached the same way, by first jumping to an address two bytes below the top of the space.

// File: rtl/brl_pkg.sv
package brl_pkg;

    localparam int WORD_W_DEF   = 32;
    localparam int NARROW_W_DEF = 24;
    localparam int IDX_W_DEF    = 4;

    typedef enum logic [2:0] {
        OP_LINK_R     = 3'd0,
        OP_LINK_X     = 3'd1,
        OP_STORE_R    = 3'd2,
        OP_STORE_X    = 3'd3,
        OP_SAVEMODE_R = 3'd4,
        OP_SETMODE_R  = 3'd5,
        OP_CONDBR_R   = 3'd6,
        OP_RSVD       = 3'd7
    } brl_op_e;

    typedef enum logic [2:0] {
        LK_NONE,
        LK_STATUS,
        LK_FULL,
        LK_SAVEMODE,
        LK_OPTMODE
    } brl_link_e;

    typedef struct packed {
        logic      legal;
        logic      reg_form;
        logic      conditional;
        logic      sets_mode;
        brl_link_e link_kind;
    } brl_cls_t;

    function automatic brl_cls_t brl_decode(brl_op_e op);
        brl_cls_t c;
        c.legal       = 1'b1;
        c.reg_form    = 1'b1;
        c.conditional = 1'b0;
        c.sets_mode   = 1'b0;
        c.link_kind   = LK_NONE;
        unique case (op)
            OP_LINK_R:     c.link_kind = LK_STATUS;
            OP_LINK_X:     begin c.link_kind = LK_STATUS; c.reg_form = 1'b0; end
            OP_STORE_R:    c.link_kind = LK_FULL;
            OP_STORE_X:    begin c.link_kind = LK_FULL;   c.reg_form = 1'b0; end
            OP_SAVEMODE_R: begin c.link_kind = LK_SAVEMODE; c.sets_mode = 1'b1; end
            OP_SETMODE_R:  begin c.link_kind = LK_OPTMODE;  c.sets_mode = 1'b1; end
            OP_CONDBR_R:   c.conditional = 1'b1;
            default:       c.legal = 1'b0;
        endcase
        return c;
    endfunction

    // mask bit 3 pairs with code 0, bit 0 with code 3
    function automatic logic brl_cond_hit(logic [3:0] mask, logic [1:0] cc);
        return mask[~cc];
    endfunction

    // length code counts halfwords of the instruction
    function automatic logic [1:0] brl_ilc(logic reg_form);
        return reg_form ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/brl_seq.sv
module brl_seq #(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 24
) (
    input  logic [WORD_W-2:0] cur_addr,
    input  logic              amode,
    input  logic              reg_form,
    output logic [WORD_W-2:0] ret_addr
);
    localparam int AW = WORD_W - 1;

    logic [AW-1:0] step;
    logic [AW-1:0] sum;

    assign step = reg_form ? AW'(2) : AW'(4);
    assign sum  = cur_addr + step;

    always_comb begin
        if (amode) begin
            ret_addr = sum;
        end else begin
            ret_addr = '0;
            ret_addr[NARROW_W-1:0] = sum[NARROW_W-1:0];
        end
    end
endmodule

// File: rtl/brl_target.sv
module brl_target
    import brl_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 24,
    parameter int IDX_W    = 4
) (
    input  brl_cls_t          cls,
    input  logic [IDX_W-1:0]  f1,
    input  logic [IDX_W-1:0]  f2,
    input  logic [WORD_W-1:0] r2_val,
    input  logic [WORD_W-1:0] ea,
    input  logic [1:0]        cc,
    input  logic [WORD_W-2:0] cur_addr,
    input  logic              amode,
    input  logic [WORD_W-2:0] ret_addr,
    output logic [WORD_W-2:0] nxt_addr,
    output logic              nxt_mode
);
    localparam int AW = WORD_W - 1;

    logic [WORD_W-1:0] src;
    logic              has_tgt;
    logic              take;
    logic              tgt_mode;
    logic [AW-1:0]     tgt_addr;

    assign src      = cls.reg_form ? r2_val : ea;
    assign has_tgt  = cls.reg_form ? (f2 != '0) : 1'b1;
    assign take     = has_tgt && (!cls.conditional || brl_cond_hit(f1[3:0], cc));
    assign tgt_mode = cls.sets_mode ? src[WORD_W-1] : amode;

    always_comb begin
        if (tgt_mode) begin
            tgt_addr = src[AW-1:0];
        end else begin
            tgt_addr = '0;
            tgt_addr[NARROW_W-1:0] = src[NARROW_W-1:0];
        end
    end

    always_comb begin
        if (!cls.legal) begin
            nxt_addr = cur_addr;
            nxt_mode = amode;
        end else if (take) begin
            nxt_addr = tgt_addr;
            nxt_mode = tgt_mode;
        end else begin
            nxt_addr = ret_addr;
            nxt_mode = amode;
        end
    end
endmodule

// File: rtl/brl_link.sv
module brl_link
    import brl_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 24,
    parameter int IDX_W    = 4
) (
    input  brl_cls_t          cls,
    input  logic [IDX_W-1:0]  f1,
    input  logic [WORD_W-1:0] r1_val,
    input  logic [WORD_W-2:0] ret_addr,
    input  logic              amode,
    input  logic [1:0]        cc,
    input  logic [3:0]        pmask,
    output logic              link_we,
    output logic [WORD_W-1:0] link_val
);
    localparam int AW = WORD_W - 1;

    always_comb begin
        link_we  = 1'b0;
        link_val = '0;
        if (cls.legal) begin
            unique case (cls.link_kind)
                LK_STATUS: begin
                    link_we  = 1'b1;
                    link_val[NARROW_W-1:0] = ret_addr[NARROW_W-1:0];
                    link_val[WORD_W-1 -: 8] = {brl_ilc(cls.reg_form), cc, pmask};
                end
                LK_FULL: begin
                    link_we  = 1'b1;
                    link_val = {1'b0, ret_addr};
                end
                LK_SAVEMODE: begin
                    link_we  = 1'b1;
                    link_val = {amode, ret_addr};
                end
                LK_OPTMODE: begin
                    link_we  = (f1 != '0);
                    link_val = {amode, r1_val[AW-1:0]};
                end
                default: begin
                    link_we  = 1'b0;
                    link_val = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/brl_unit.sv
module brl_unit
    import brl_pkg::*;
#(
    parameter int WORD_W   = WORD_W_DEF,
    parameter int NARROW_W = NARROW_W_DEF,
    parameter int IDX_W    = IDX_W_DEF,
    parameter logic [WORD_W-2:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [IDX_W-1:0]  in_f1,
    input  logic [IDX_W-1:0]  in_f2,
    input  logic [WORD_W-1:0] in_r1_val,
    input  logic [WORD_W-1:0] in_r2_val,
    input  logic [WORD_W-1:0] in_ea,
    input  logic [1:0]        in_cc,
    input  logic [3:0]        in_pmask,
    output logic [WORD_W-2:0] pc_addr,
    output logic              pc_amode,
    output logic              lk_we,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [WORD_W-1:0] lk_val
);
    localparam int AW = WORD_W - 1;

    brl_op_e           op;
    brl_cls_t          cls;
    logic [AW-1:0]     ret_addr;
    logic [AW-1:0]     nxt_addr;
    logic              nxt_mode;
    logic              link_we;
    logic [WORD_W-1:0] link_val;

    assign op  = brl_op_e'(in_op);
    assign cls = brl_decode(op);

    brl_seq #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_seq (
        .cur_addr (pc_addr),
        .amode    (pc_amode),
        .reg_form (cls.reg_form),
        .ret_addr (ret_addr)
    );

    brl_target #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_tgt (
        .cls      (cls),
        .f1       (in_f1),
        .f2       (in_f2),
        .r2_val   (in_r2_val),
        .ea       (in_ea),
        .cc       (in_cc),
        .cur_addr (pc_addr),
        .amode    (pc_amode),
        .ret_addr (ret_addr),
        .nxt_addr (nxt_addr),
        .nxt_mode (nxt_mode)
    );

    brl_link #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_lnk (
        .cls      (cls),
        .f1       (in_f1),
        .r1_val   (in_r1_val),
        .ret_addr (ret_addr),
        .amode    (pc_amode),
        .cc       (in_cc),
        .pmask    (in_pmask),
        .link_we  (link_we),
        .link_val (link_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_addr  <= RESET_ADDR;
            pc_amode <= 1'b0;
            lk_we    <= 1'b0;
            lk_idx   <= '0;
            lk_val   <= '0;
        end else if (in_valid) begin
            pc_addr  <= nxt_addr;
            pc_amode <= nxt_mode;
            lk_we    <= link_we;
            lk_idx   <= in_f1;
            lk_val   <= link_val;
        end else begin
            lk_we    <= 1'b0;
        end
    end
endmodule

// File: rtl/brl_unit_chk.sv
module brl_unit_chk #(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 24,
    parameter int IDX_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [IDX_W-1:0]  in_f1,
    input logic [IDX_W-1:0]  in_f2,
    input logic [WORD_W-2:0] pc_addr,
    input logic              pc_amode,
    input logic              lk_we,
    input logic [WORD_W-1:0] lk_val
);
    localparam int AW = WORD_W - 1;

    logic          is_reg;
    logic [AW-1:0] fall2;

    assign is_reg = (in_op == 3'd0) || (in_op == 3'd2) || (in_op == 3'd4) ||
                    (in_op == 3'd5) || (in_op == 3'd6);

    always_comb begin
        fall2 = pc_addr + AW'(2);
        if (!pc_amode) fall2[AW-1:NARROW_W] = '0;
    end

    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        !pc_amode |-> (pc_addr[AW-1:NARROW_W] == '0)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pc_addr) && $stable(pc_amode) && !lk_we)); // R11

    AST_COND_NO_LINK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd6) |=> !lk_we); // R8

    AST_NO_TARGET_FALLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_reg && in_f2 == '0) |=>
            (pc_addr == $past(fall2) && pc_amode == $past(pc_amode))); // R9

    AST_SAVE_MODE_BIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4) |=> (lk_we && lk_val[WORD_W-1] == $past(pc_amode))); // R6

    AST_RET_NO_SAVE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd5 && in_f1 == '0) |=> !lk_we); // R7
endmodule

bind brl_unit brl_unit_chk #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_f1    (in_f1),
    .in_f2    (in_f2),
    .pc_addr  (pc_addr),
    .pc_amode (pc_amode),
    .lk_we    (lk_we),
    .lk_val   (lk_val)
);

// File: tb/brl_unit_bench.sv
`timescale 1ns/1ps
module brl_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [3:0]  in_f1, in_f2;
    logic [31:0] in_r1_val, in_r2_val, in_ea;
    logic [1:0]  in_cc;
    logic [3:0]  in_pmask;
    logic [30:0] pc_addr;
    logic        pc_amode;
    logic        lk_we;
    logic [3:0]  lk_idx;
    logic [31:0] lk_val;

    always #10 clk = ~clk;

    brl_unit u_brl_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_f1(in_f1), .in_f2(in_f2), .in_r1_val(in_r1_val), .in_r2_val(in_r2_val),
        .in_ea(in_ea), .in_cc(in_cc), .in_pmask(in_pmask),
        .pc_addr(pc_addr), .pc_amode(pc_amode), .lk_we(lk_we),
        .lk_idx(lk_idx), .lk_val(lk_val)
    );

    typedef struct {
        logic [30:0] a;
        logic        m;
        logic        we;
        logic [3:0]  idx;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [30:0] m_a;
    logic        m_m;
    logic [31:0] last_link;

    function automatic logic [30:0] narrow(logic [31:0] w, logic md);
        return md ? w[30:0] : {7'd0, w[23:0]};
    endfunction

    task automatic issue(input bit v, input logic [2:0] op, input logic [3:0] f1,
                         input logic [3:0] f2, input logic [31:0] r1, input logic [31:0] r2,
                         input logic [31:0] ea, input logic [1:0] cc, input logic [3:0] pm,
                         input string req);
        exp_t        e;
        logic [30:0] ret;
        bit          br;
        @(negedge clk);
        in_valid = v; in_op = op; in_f1 = f1; in_f2 = f2; in_r1_val = r1;
        in_r2_val = r2; in_ea = ea; in_cc = cc; in_pmask = pm;
        ret = m_a + ((op == 3'd1 || op == 3'd3) ? 31'd4 : 31'd2);
        if (!m_m) ret[30:24] = '0;
        e.a = m_a; e.m = m_m; e.we = 1'b0; e.idx = f1; e.val = '0; e.req = req;
        if (v) begin
            case (op)
                3'd0, 3'd1, 3'd2, 3'd3: begin
                    e.we  = 1'b1;
                    e.val = (op < 3'd2) ? {(op == 3'd0 ? 2'b01 : 2'b10), cc, pm, ret[23:0]}
                                        : {1'b0, ret};
                    br    = (op == 3'd1 || op == 3'd3) || (f2 != 0);
                    e.a   = br ? narrow((op == 3'd1 || op == 3'd3) ? ea : r2, m_m) : ret;
                end
                3'd4, 3'd5: begin
                    e.we  = (op == 3'd4) || (f1 != 0);
                    e.val = (op == 3'd4) ? {m_m, ret} : {m_m, r1[30:0]};
                    if (f2 != 0) begin
                        e.m = r2[31];
                        e.a = narrow(r2, r2[31]);
                    end else begin
                        e.a = ret;
                    end
                end
                3'd6: begin
                    br  = (f2 != 0) && f1[3 - cc];
                    e.a = br ? narrow(r2, m_m) : ret;
                end
                default: ;
            endcase
        end
        m_a = e.a; m_m = e.m;
        if (e.we) last_link = e.val;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        issue(0, 3'd0, 4'd0, 4'd0, 32'd0, 32'd0, 32'd0, 2'd0, 4'd0, req);
    endtask

    task automatic go(input logic [31:0] w);  // place state with no link write
        issue(1, 3'd5, 4'd0, 4'd1, 32'd0, w, 32'd0, 2'd0, 4'd0, "R7");
    endtask

    always @(posedge clk) begin
        #5;
        if (!done && q.size() > 0) begin
            exp_t e;
            bit   ok;
            e  = q.pop_front();
            ok = (pc_addr == e.a) && (pc_amode == e.m) && (lk_we == e.we) &&
                 (!e.we || (lk_idx == e.idx && lk_val == e.val));
            n_chk++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s: got a=%h m=%b we=%b idx=%0d val=%h exp a=%h m=%b we=%b idx=%0d val=%h",
                         e.req, pc_addr, pc_amode, lk_we, lk_idx, lk_val,
                         e.a, e.m, e.we, e.idx, e.val);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got running exp finished");
        finish_run();
    end

    initial begin
        rst = 1; in_valid = 0; in_op = 0; in_f1 = 0; in_f2 = 0;
        in_r1_val = 0; in_r2_val = 0; in_ea = 0; in_cc = 0; in_pmask = 0;
        m_a = '0; m_m = 0; last_link = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        n_chk++;
        if (pc_addr != 0 || pc_amode != 0 || lk_we != 0) begin
            n_bad++;
            $display("FAIL R1: got a=%h m=%b we=%b exp a=0 m=0 we=0", pc_addr, pc_amode, lk_we);
        end

        // R3 R5: link word with status byte, target narrowed in mode 0
        issue(1, 3'd0, 4'd14, 4'd15, 0, 32'h8123_4567, 0, 2'd2, 4'hA, "R3");
        issue(1, 3'd1, 4'd3, 4'd0, 0, 0, 32'hFF00_1000, 2'd1, 4'h5, "R3");
        // R4: store calls
        issue(1, 3'd2, 4'd7, 4'd9, 0, 32'h0000_2200, 0, 2'd3, 4'hF, "R4");
        issue(1, 3'd3, 4'd8, 4'd0, 0, 0, 32'h0012_3456, 2'd0, 4'h0, "R4");
        // R5: mode 1 keeps 31 bits, ignores bit 31
        go(32'h8000_0100);
        issue(1, 3'd2, 4'd2, 4'd3, 0, 32'hFFAB_CDEF, 0, 0, 0, "R5");
        issue(1, 3'd0, 4'd2, 4'd3, 0, 32'h7FFF_0000, 0, 2'd3, 4'h1, "R3");
        // R8: every mask bit against every condition code
        for (int c = 0; c < 4; c++)
            for (int b = 0; b < 4; b++)
                issue(1, 3'd6, 4'(1 << b), 4'd5, 0, 32'h0000_4000 + 32'(c * 16 + b * 4),
                      0, 2'(c), 0, "R8");
        // R9: register forms with no target register
        issue(1, 3'd0, 4'd1, 4'd0, 0, 32'h0000_9999, 0, 0, 0, "R9");
        issue(1, 3'd2, 4'd1, 4'd0, 0, 32'h0000_9999, 0, 0, 0, "R9");
        issue(1, 3'd4, 4'd1, 4'd0, 0, 32'h8000_9999, 0, 0, 0, "R9");
        issue(1, 3'd5, 4'd6, 4'd0, 32'h1234_5678, 32'h0000_9999, 0, 0, 0, "R9");
        issue(1, 3'd6, 4'hF, 4'd0, 0, 32'h0000_9999, 0, 0, 0, "R9");
        // R11: idle and reserved code
        idle("R11");
        issue(1, 3'd7, 4'd4, 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R11");
        idle("R11");
        // R2: wrap at both widths
        go(32'h00FF_FFFE);
        issue(1, 3'd6, 4'd0, 4'd1, 0, 0, 0, 0, 0, "R2");
        go(32'hFFFF_FFFE);
        issue(1, 3'd6, 4'd0, 4'd1, 0, 0, 0, 0, 0, "R2");
        go(32'h0000_FFFE);
        issue(1, 3'd3, 4'd1, 4'd0, 0, 0, 32'h0000_0040, 0, 0, "R2");
        // R10: link register equals target register
        go(32'h0000_0200);
        issue(1, 3'd4, 4'd5, 4'd5, 0, 32'h8000_3000, 0, 0, 0, "R10");
        issue(1, 3'd5, 4'd5, 4'd5, 32'h0000_0204, 32'h0000_0204, 0, 0, 0, "R10");
        // R12: four call/return mode pairs
        for (int cm = 0; cm < 2; cm++)
            for (int tm = 0; tm < 2; tm++) begin
                go({1'(cm), 31'h0000_1000 + 31'(cm * 64 + tm * 8)});
                issue(1, 3'd4, 4'd14, 4'd15, 0, {1'(tm), 31'h0055_0000}, 0, 0, 0, "R12");
                issue(1, 3'd5, 4'd0, 4'd14, 0, last_link, 0, 0, 0, "R12");
            end
        // R6 R7 and all others: random traffic
        for (int i = 0; i < 600; i++)
            issue(1'($urandom_range(0, 9) != 0), 3'($urandom), 4'($urandom), 4'($urandom_range(0, 3)),
                  $urandom, $urandom, $urandom, 2'($urandom), 4'($urandom), "R6/R7 random");
        idle("R11");
        idle("R11");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule